// File: doc/BRIEF.md
# Dual-Rail Full Adder with Latched Alarm

This block adds three one-bit operands (`a`, `b` and a carry-in `cin`) where every logical bit travels on a pair of wires. The true rail sits at bit 1 and the false rail at bit 0. Both wires low is the null (spacer) state, and only one wire high is a data value. Both wires high is an illegal code that the block treats as a tamper or fault alarm. The adder does not produce a result until all three operands hold valid codes. It then forms one-hot minterms through state-holding consensus cells, and an OR plane over those minterms gives the dual-rail sum and carry-out. Because every combination fires exactly one minterm, the number of wire transitions and the latency are the same for every data value.

The consensus (Muller) cells are modelled as clocked state-holding registers. Each one rises when all of its inputs are high, falls when all are low, and holds otherwise. A result therefore stays on the outputs until every operand has gone back to null, and the next operand set can only start after that spacer phase.

An illegal code on any operand sets a sticky alarm latch in which reset dominates. While the alarm is set, all four output rails are forced high, which deadlocks any downstream completion logic. Only the reset input releases it.

Top module: `dr_full_adder`

## Requirements
- R1: Rail encoding on every operand and output: bit 1 is the true rail and bit 0 the false rail. 2'b00 is null, 2'b01 is logic 0, 2'b10 is logic 1, and 2'b11 is the alarm code.
- R2: When all three operands are valid, `sum` carries the XOR of the three logical values and `cout` carries their majority, both in the R1 encoding. This holds for all eight combinations.
- R3: The outputs become valid at the first rising clock edge after the last operand becomes valid, never earlier. This latency is the same for every data combination.
- R4: From the null state, while any operand is 2'b00, `sum` and `cout` stay 2'b00.
- R5: A valid result holds while only some operands have returned to null. It returns to 2'b00 at the first rising edge after all three operands are null.
- R6: A 2'b11 code on any single operand sets `alarm` at the next rising edge. From that edge onward, `sum` and `cout` both read 2'b11. This applies whether the other operands are valid or null.
- R7: Once set, `alarm` and the forced 2'b11 outputs persist whatever the operands do, until `rst_n` is driven low.
- R8: While `rst_n` is low and after it is released, `sum` = `cout` = 2'b00 and `alarm` = 0, with all internal state cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the consensus cells and the alarm latch |
| rst_n | input | 1 | Asynchronous active-low reset; dominates the alarm latch |
| a | input | 2 | Operand a, dual-rail {true, false} |
| b | input | 2 | Operand b, dual-rail {true, false} |
| cin | input | 2 | Carry-in, dual-rail {true, false} |
| sum | output | 2 | Sum, dual-rail {true, false} |
| cout | output | 2 | Carry-out, dual-rail {true, false} |
| alarm | output | 1 | Latched alarm flag |

## Verification
The hardest state to reach from the ports is a partially withdrawn operand set. One or two operands have returned to null while the others still hold data. The consensus cells must keep their value here, and a premature drop of the result would show up only in this window. The stimulus reaches it by withdrawing the operands one at a time, sampling the outputs after each step. It does the same in the other direction, presenting operands one by one from the null state so that the result must not appear early. For the alarm, each operand in turn carries the illegal code. Valid and null operands are then applied before reset, to show that nothing except reset clears the latch.

// File: rtl/dr_pkg.sv
package dr_pkg;
   localparam int NUM_OPS      = 3;
   localparam int NUM_MINTERMS = 1 << NUM_OPS;

   typedef logic [1:0] rail_t;

   localparam rail_t RAIL_NULL  = 2'b00;
   localparam rail_t RAIL_ZERO  = 2'b01;
   localparam rail_t RAIL_ONE   = 2'b10;
   localparam rail_t RAIL_ALARM = 2'b11;
endpackage

// File: rtl/dr_celem.sv
module dr_celem #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] x,
   output logic         y
);
   if (N < 2) begin : g_bad_n
      $error("dr_celem: N must be at least 2");
   end

   logic all_hi;
   logic all_lo;
   assign all_hi = &x;
   assign all_lo = ~|x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      y <= 1'b0;
      else if (all_hi) y <= 1'b1;
      else if (all_lo) y <= 1'b0;
   end

   // R5: mixed inputs leave the cell unchanged
   p_celem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_hi && !all_lo) |=> $stable(y));
endmodule

// File: rtl/dr_minterm_expand.sv
module dr_minterm_expand
   import dr_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  rail_t [NUM_OPS-1:0]           ops,
   output logic  [NUM_MINTERMS-1:0]      mt
);
   for (genvar gi = 0; gi < NUM_MINTERMS; gi++) begin : g_mt
      localparam logic [NUM_OPS-1:0] IDX = NUM_OPS'(gi);
      logic [NUM_OPS-1:0] pick;
      for (genvar k = 0; k < NUM_OPS; k++) begin : g_rail
         assign pick[k] = ops[k][IDX[k]];
      end
      dr_celem #(.N(NUM_OPS)) i_cel (
         .clk  (clk),
         .rst_n(rst_n),
         .x    (pick),
         .y    (mt[gi])
      );
   end

   // R2: with legal codes at most one minterm is ever high
   p_mt_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((ops[0] != RAIL_ALARM) && (ops[1] != RAIL_ALARM) && (ops[2] != RAIL_ALARM)
       && $onehot0(mt)) |=> $onehot0(mt));
endmodule

// File: rtl/dr_alarm_latch.sv
module dr_alarm_latch
   import dr_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  rail_t [NUM_OPS-1:0] ops,
   output logic                alarm_q
);
   logic hit;
   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < NUM_OPS; k++) hit = hit | (&ops[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   alarm_q <= 1'b0;
      else if (hit) alarm_q <= 1'b1;
   end

   // R7: latch never clears while out of reset
   p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_q |=> alarm_q);
endmodule

// File: rtl/dr_or_plane.sv
module dr_or_plane
   import dr_pkg::*;
(
   input  logic [NUM_MINTERMS-1:0] mt,
   input  logic                    force_all,
   output rail_t                   sum,
   output rail_t                   cout
);
   if (NUM_OPS != 3) begin : g_bad_ops
      $error("dr_or_plane: full adder needs exactly three operands");
   end

   logic [NUM_MINTERMS-1:0] odd_sel;
   logic [NUM_MINTERMS-1:0] maj_sel;

   for (genvar gi = 0; gi < NUM_MINTERMS; gi++) begin : g_sel
      localparam logic [NUM_OPS-1:0] IDX = NUM_OPS'(gi);
      localparam int ONES = $countones(IDX);
      assign odd_sel[gi] = ((ONES % 2) == 1);
      assign maj_sel[gi] = ((2 * ONES) > NUM_OPS);
   end

   assign sum[1]  = (|(mt &  odd_sel)) | force_all;
   assign sum[0]  = (|(mt & ~odd_sel)) | force_all;
   assign cout[1] = (|(mt &  maj_sel)) | force_all;
   assign cout[0] = (|(mt & ~maj_sel)) | force_all;
endmodule

// File: rtl/dr_full_adder.sv
module dr_full_adder
   import dr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] a,
   input  logic [1:0] b,
   input  logic [1:0] cin,
   output logic [1:0] sum,
   output logic [1:0] cout,
   output logic       alarm
);
   rail_t [NUM_OPS-1:0]      ops;
   logic  [NUM_MINTERMS-1:0] mt;
   rail_t                    sum_w;
   rail_t                    cout_w;

   assign ops[2] = a;
   assign ops[1] = b;
   assign ops[0] = cin;

   dr_minterm_expand i_expand (
      .clk  (clk),
      .rst_n(rst_n),
      .ops  (ops),
      .mt   (mt)
   );

   dr_alarm_latch i_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .ops    (ops),
      .alarm_q(alarm)
   );

   dr_or_plane i_plane (
      .mt       (mt),
      .force_all(alarm),
      .sum      (sum_w),
      .cout     (cout_w)
   );

   assign sum  = sum_w;
   assign cout = cout_w;

   // R6: illegal code on any operand raises the alarm at the next edge
   p_alarm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((a == RAIL_ALARM) || (b == RAIL_ALARM) || (cin == RAIL_ALARM)) |=> alarm);

   // R6: alarm forces every output rail high
   p_alarm_forces_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm |-> ((sum == RAIL_ALARM) && (cout == RAIL_ALARM)));

   // R1: without alarm the outputs never show the illegal code
   p_legal_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm |-> ($countones(sum) <= 1 && $countones(cout) <= 1));

   // R5: all-null operands return the outputs to null at the next edge
   p_spacer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (a == RAIL_NULL && b == RAIL_NULL && cin == RAIL_NULL && !alarm)
      |=> (sum == RAIL_NULL && cout == RAIL_NULL));

   // R2: sum and carry rails become valid together
   p_pair_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm |-> ((sum == RAIL_NULL) == (cout == RAIL_NULL)));
endmodule

// File: tb/test_dr_full_adder.sv
module test_dr_full_adder;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] a = 2'b00, b = 2'b00, cin = 2'b00;
   logic [1:0] sum, cout;
   logic       alarm;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dr_full_adder i_dr_full_adder (
      .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
      .sum(sum), .cout(cout), .alarm(alarm)
   );

   function automatic logic [1:0] enc(input logic v);
      return v ? 2'b10 : 2'b01;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [4:0] act, input logic [4:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual sum/cout/alarm=%b expected %b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; a = 2'b00; b = 2'b00; cin = 2'b00;
      #1;
      chk("R8", "during reset", {sum, cout, alarm}, 5'b00000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "after reset", {sum, cout, alarm}, 5'b00000);
   endtask

   // R2 R3 R5: every combination, spacer between each
   task automatic t_all_combos();
      for (int m = 0; m < 8; m++) begin
         logic va, vb, vc;
         va = m[2]; vb = m[1]; vc = m[0];
         a = enc(va); b = enc(vb); cin = enc(vc);
         #1;
         chk("R3", "no early result", {sum, cout, alarm}, 5'b00000);
         @(negedge clk);
         chk("R2", $sformatf("combo %0d", m), {sum, cout, alarm},
             {enc(va ^ vb ^ vc), enc((va & vb) | (va & vc) | (vb & vc)), 1'b0});
         a = 2'b00; b = 2'b00; cin = 2'b00;
         @(negedge clk);
         chk("R5", $sformatf("spacer after %0d", m), {sum, cout, alarm}, 5'b00000);
      end
   endtask

   // R4 R3: operands arrive one at a time
   task automatic t_partial();
      a = enc(1'b1);
      repeat (2) @(negedge clk);
      chk("R4", "only a valid", {sum, cout, alarm}, 5'b00000);
      b = enc(1'b0);
      repeat (3) @(negedge clk);
      chk("R4", "cin still null", {sum, cout, alarm}, 5'b00000);
      cin = enc(1'b1);
      @(negedge clk);
      chk("R3", "late cin completes", {sum, cout, alarm}, {2'b01, 2'b10, 1'b0});
      a = 2'b00; b = 2'b00; cin = 2'b00;
      @(negedge clk);
   endtask

   // R5: withdraw operands one by one
   task automatic t_hold();
      a = enc(1'b1); b = enc(1'b1); cin = enc(1'b1);
      @(negedge clk);
      chk("R2", "1+1+1", {sum, cout, alarm}, {2'b10, 2'b10, 1'b0});
      a = 2'b00;
      @(negedge clk);
      chk("R5", "hold with a null", {sum, cout, alarm}, {2'b10, 2'b10, 1'b0});
      b = 2'b00;
      repeat (2) @(negedge clk);
      chk("R5", "hold with a,b null", {sum, cout, alarm}, {2'b10, 2'b10, 1'b0});
      cin = 2'b00;
      @(negedge clk);
      chk("R5", "all null clears", {sum, cout, alarm}, 5'b00000);
   endtask

   // R6 R7: illegal code on operand k; others valid or null
   task automatic t_alarm(input int k, input bit others_valid);
      logic [1:0] o;
      o = others_valid ? enc(1'b1) : 2'b00;
      a = (k == 2) ? 2'b11 : o;
      b = (k == 1) ? 2'b11 : o;
      cin = (k == 0) ? 2'b11 : o;
      @(negedge clk);
      chk("R6", $sformatf("alarm on op %0d", k), {sum, cout, alarm}, 5'b11111);
      a = 2'b00; b = 2'b00; cin = 2'b00;
      repeat (2) @(negedge clk);
      chk("R7", "alarm after spacer", {sum, cout, alarm}, 5'b11111);
      a = enc(1'b0); b = enc(1'b1); cin = enc(1'b0);
      repeat (2) @(negedge clk);
      chk("R7", "alarm with valid data", {sum, cout, alarm}, 5'b11111);
      do_reset();
   endtask

   initial begin
      do_reset();
      t_all_combos();
      t_partial();
      t_hold();
      t_alarm(2, 1'b1);
      t_alarm(1, 1'b1);
      t_alarm(0, 1'b1);
      t_alarm(1, 1'b0);
      a = enc(1'b0); b = enc(1'b1); cin = enc(1'b1);
      @(negedge clk);
      chk("R1", "clean after alarm reset", {sum, cout, alarm}, {2'b01, 2'b10, 1'b0});
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule